// File: doc/BRIEF.md
# Machine Cycle Strobe Generator

This block turns the raw oscillator clock of a multiplexed-bus microcontroller into its bus timing. A phase counter splits every machine cycle into twelve oscillator periods. From the phase, the block produces four outputs: an address latch enable strobe that pulses twice per machine cycle, a program-store-enable strobe (active low) that reads external code memory while a fetch is pending, a one-period pulse that marks the first phase of each machine cycle, and the phase index itself.

The fetch request is sampled once, on the clock edge that starts a machine cycle. It then controls the code-read strobe for that whole cycle, so the strobe pattern is never cut short or extended part-way through a cycle. All strobes come straight from registers. The reset input asserts asynchronously and is released synchronously through a two-stage synchronizer.

Top module: `mcg_bus_timing`

## Requirements
- R1: The phase index counts 0, 1, ... 11 and then returns to 0, advancing by one on every clock edge once reset has been released.
- R2: The cycle-start output is high during phase 0 of every machine cycle and low during phases 1 to 11.
- R3: The address latch enable is high in phases 0, 1, 6 and 7 and low in all other phases, which is four of every twelve periods.
- R4: When the fetch flag captured for a machine cycle is 1, the code-read strobe is low in phases 3, 4, 5, 9, 10 and 11 and high in the other phases.
- R5: The fetch request is sampled only on the clock edge that enters phase 0. A change of the request during phases 0 to 10 has no effect on the code-read strobe until the next machine cycle.
- R6: When the fetch flag captured for a machine cycle is 0, the code-read strobe stays high for the whole cycle.
- R7: While the reset input is low, the phase index is 0, the latch enable is low, the code-read strobe is high and the cycle-start output is low. This takes effect at once, without waiting for a clock edge. The strobes stay in these idle values until the counter first advances.
- R8: After the reset input is released, the phase index stays at 0 for two clock edges and moves to 1 on the third.
- R9: The latch enable is never high in a period where the code-read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_req | input | 1 | Request a code fetch in the next machine cycle |
| ale_o | output | 1 | Address latch enable strobe |
| psen_n_o | output | 1 | Code-read strobe, active low |
| cycle_start_o | output | 1 | High during phase 0 of each machine cycle |
| phase_o | output | 4 | Current phase, 0 to 11 |

## Verification
Sampling of the fetch request and the start of the address strobe happen on the same clock edge: the one that moves the counter from phase 11 to phase 0. The bench sets the request while phase 11 is showing, so it is the value captured at the boundary. It then checks that the cycle-start pulse, the rising latch enable and the code-read pattern all line up in phase 0 and in the phases after it. In some cycles the bench also flips the request in phase 2. It then confirms that the code-read strobe keeps the pattern set by the value captured at the boundary until phase 11.

// File: rtl/mcg_pkg.sv
`timescale 1ns/1ps
package mcg_pkg;

  // Registered strobe bundle leaving the decoder.
  typedef struct packed {
    logic ale;
    logic psen_n;
    logic start;
  } mcg_strobe_t;

  localparam mcg_strobe_t MCG_STROBE_IDLE = '{ale: 1'b0, psen_n: 1'b1, start: 1'b0};

endpackage

// File: rtl/mcg_rst_sync.sv
`timescale 1ns/1ps
module mcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mcg_phase_cnt.sv
`timescale 1ns/1ps
module mcg_phase_cnt #(
  parameter int PHASES = 12,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [PW-1:0] phase_q,
  output logic [PW-1:0] phase_nxt,
  output logic          wrap_nxt
);

  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  always_comb begin
    phase_nxt = phase_q;
    wrap_nxt  = 1'b0;
    if (en) begin
      if (phase_q == LAST) begin
        phase_nxt = '0;
        wrap_nxt  = 1'b1;
      end else begin
        phase_nxt = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= phase_nxt;
    end
  end

endmodule

// File: rtl/mcg_strobe_dec.sv
`timescale 1ns/1ps
module mcg_strobe_dec
  import mcg_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int PW         = $clog2(PHASES),
  parameter int ALE_LEN    = 2,
  parameter int PSEN_START = 3,
  parameter int PSEN_LEN   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] phase_nxt,
  input  logic          wrap_nxt,
  input  logic          fetch_req,
  output mcg_strobe_t   strobe_q
);

  localparam int HALF  = PHASES / 2;
  localparam int SLOTS = 2;

  logic             fetch_q;
  logic             fetch_d;
  logic [SLOTS-1:0] ale_hit;
  logic [SLOTS-1:0] psen_hit;
  mcg_strobe_t      strobe_d;

  // One address window and one code-read window per half cycle.
  for (genvar h = 0; h < SLOTS; h++) begin : g_half
    localparam logic [PW-1:0] A_LO = PW'(h * HALF);
    localparam logic [PW-1:0] A_HI = PW'(h * HALF + ALE_LEN);
    localparam logic [PW-1:0] P_LO = PW'(h * HALF + PSEN_START);
    localparam logic [PW-1:0] P_HI = PW'(h * HALF + PSEN_START + PSEN_LEN);
    always_comb begin
      ale_hit[h]  = (phase_nxt >= A_LO) && (phase_nxt < A_HI);
      psen_hit[h] = (phase_nxt >= P_LO) && (phase_nxt < P_HI);
    end
  end

  always_comb begin
    fetch_d         = wrap_nxt ? fetch_req : fetch_q;
    strobe_d.ale    = |ale_hit;
    strobe_d.psen_n = !(fetch_d && (|psen_hit));
    strobe_d.start  = (phase_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q  <= 1'b0;
      strobe_q <= MCG_STROBE_IDLE;
    end else if (en) begin
      fetch_q  <= fetch_d;
      strobe_q <= strobe_d;
    end
  end

endmodule

// File: rtl/mcg_bus_timing.sv
`timescale 1ns/1ps
module mcg_bus_timing
  import mcg_pkg::*;
#(
  parameter int PHASES     = 12,
  parameter int PW         = 4,
  parameter int ALE_LEN    = 2,
  parameter int PSEN_START = 3,
  parameter int PSEN_LEN   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_req,
  output logic          ale_o,
  output logic          psen_n_o,
  output logic          cycle_start_o,
  output logic [PW-1:0] phase_o
);

  logic          rst_sync_n;
  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_nxt;
  logic          wrap_nxt;
  mcg_strobe_t   strobe_q;

  mcg_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mcg_phase_cnt #(.PHASES(PHASES), .PW(PW)) i_phase_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (rst_sync_n),
    .phase_q   (phase_q),
    .phase_nxt (phase_nxt),
    .wrap_nxt  (wrap_nxt)
  );

  mcg_strobe_dec #(
    .PHASES     (PHASES),
    .PW         (PW),
    .ALE_LEN    (ALE_LEN),
    .PSEN_START (PSEN_START),
    .PSEN_LEN   (PSEN_LEN)
  ) i_strobe_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (rst_sync_n),
    .phase_nxt (phase_nxt),
    .wrap_nxt  (wrap_nxt),
    .fetch_req (fetch_req),
    .strobe_q  (strobe_q)
  );

  assign phase_o       = phase_q;
  assign ale_o         = strobe_q.ale;
  assign psen_n_o      = strobe_q.psen_n;
  assign cycle_start_o = strobe_q.start;

endmodule

// File: rtl/mcg_bus_timing_chk.sv
`timescale 1ns/1ps
module mcg_bus_timing_chk #(
  parameter int PHASES     = 12,
  parameter int PW         = 4,
  parameter int ALE_LEN    = 2,
  parameter int PSEN_START = 3
) (
  input logic          clk,
  input logic          run,
  input logic [PW-1:0] phase,
  input logic          ale,
  input logic          psen_n,
  input logic          cycle_start
);

  localparam int HALF = PHASES / 2;
  localparam logic [PW-1:0] LAST  = PW'(PHASES - 1);
  localparam logic [PW-1:0] AF0   = PW'(ALE_LEN);
  localparam logic [PW-1:0] AF1   = PW'(HALF + ALE_LEN);
  localparam logic [PW-1:0] PF0   = PW'(PSEN_START);
  localparam logic [PW-1:0] PF1   = PW'(HALF + PSEN_START);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!run)
    phase <= LAST); // R1
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!run)
    (phase != LAST) |=> (phase == $past(phase) + 1'b1)); // R1
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!run)
    (phase == LAST) |=> (phase == '0)); // R1
  AST_START_PHASE: assert property (@(posedge clk) disable iff (!run)
    cycle_start |-> (phase == '0)); // R2
  AST_ALE_FALL: assert property (@(posedge clk) disable iff (!run)
    $fell(ale) |-> (phase == AF0 || phase == AF1)); // R3
  AST_PSEN_OPEN: assert property (@(posedge clk) disable iff (!run)
    $fell(psen_n) |-> (phase == PF0 || phase == PF1)); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!run)
    !(ale && !psen_n)); // R9

endmodule

bind mcg_bus_timing mcg_bus_timing_chk #(
  .PHASES     (PHASES),
  .PW         (PW),
  .ALE_LEN    (ALE_LEN),
  .PSEN_START (PSEN_START)
) i_chk (
  .clk         (clk),
  .run         (rst_sync_n),
  .phase       (phase_o),
  .ale         (ale_o),
  .psen_n      (psen_n_o),
  .cycle_start (cycle_start_o)
);

// File: tb/test_mcg_bus_timing.sv
`timescale 1ns/1ps
module test_mcg_bus_timing;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  // bit1: latch enable expected high, bit0: phase inside a code-read window
  localparam logic [1:0] EXP_TAB [12] = '{
    2'b10, 2'b10, 2'b00, 2'b01, 2'b01, 2'b01,
    2'b10, 2'b10, 2'b00, 2'b01, 2'b01, 2'b01
  };

  logic       clk;
  logic       rst_n;
  logic       fetch_req;
  logic       ale_o;
  logic       psen_n_o;
  logic       cycle_start_o;
  logic [3:0] phase_o;

  int checks;
  int errors;

  mcg_bus_timing i_mcg_bus_timing (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req     (fetch_req),
    .ale_o         (ale_o),
    .psen_n_o      (psen_n_o),
    .cycle_start_o (cycle_start_o),
    .phase_o       (phase_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at the falling edge where phase 11 shows; leaves at the next one.
  task automatic run_cycle(input logic f, input logic flip);
    fetch_req = f;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R1 phase", int'(phase_o), k);
      chk("R2 cycle start", int'(cycle_start_o), (k == 0) ? 1 : 0);
      chk("R3 latch enable", int'(ale_o), int'(EXP_TAB[k][1]));
      if (f)
        chk(flip ? "R5 code read, request dropped mid cycle" : "R4 code read",
            int'(psen_n_o), EXP_TAB[k][0] ? 0 : 1);
      else
        chk(flip ? "R5 idle, request raised mid cycle" : "R6 idle code read",
            int'(psen_n_o), 1);
      chk("R9 no overlap", int'(ale_o && !psen_n_o), 0);
      if (flip && k == 2) fetch_req = !f;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    fetch_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 reset phase", int'(phase_o), 0);
    chk("R7 reset latch enable", int'(ale_o), 0);
    chk("R7 reset code read", int'(psen_n_o), 1);
    chk("R7 reset start", int'(cycle_start_o), 0);

    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 hold after release 1", int'(phase_o), 0);
    chk("R7 idle latch enable before advance", int'(ale_o), 0);
    @(negedge clk);
    chk("R8 hold after release 2", int'(phase_o), 0);
    @(negedge clk);
    chk("R8 first advance", int'(phase_o), 1);
    chk("R3 latch enable in phase 1", int'(ale_o), 1);

    for (int n = 0; n < 16 && phase_o != 4'd11; n++) @(negedge clk);
    chk("R1 reached phase 11", int'(phase_o), 11);

    run_cycle(1'b1, 1'b0);
    run_cycle(1'b0, 1'b0);
    run_cycle(1'b1, 1'b1);
    run_cycle(1'b0, 1'b1);
    run_cycle(1'b1, 1'b0);
    run_cycle(1'b1, 1'b0);

    // Asynchronous reset in mid cycle, away from any edge.
    for (int n = 0; n < 4; n++) @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R7 async phase", int'(phase_o), 0);
    chk("R7 async latch enable", int'(ale_o), 0);
    chk("R7 async code read", int'(psen_n_o), 1);
    chk("R7 async start", int'(cycle_start_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule